// File: doc/BRIEF.md
# Hashed Object Handle Table Engine

This block keeps a table of object bindings in an internal single-port RAM. Each binding pairs a 32-bit object handle with a context word that carries an instance address, an engine number and, in legacy encoding, the owning channel. A client issues one command at a time on a valid/ready request port: insert a binding, look a handle up, or remove a binding. After each command the engine returns a one-cycle response. The response holds a success flag, a status code, the slot that was used and, for a lookup hit, the decoded instance address and engine.

The home slot comes from folding the handle into HBITS bits with XOR. In legacy encoding the channel id is also mixed in. Collisions are resolved by linear open addressing: the probe moves one slot at a time and wraps from the last slot to slot 0. Each slot is two RAM words: the even word holds the handle and the odd word holds the context. A parameter selects the encoding. Legacy encoding marks a slot as occupied with a valid flag in bit 31 of its context word. The newer encoding treats any nonzero context word as occupied.

After reset the engine clears the whole RAM one word per cycle. It takes no command until the clearing has finished.

Top module: `objhash_engine`

## Requirements
- R1: The home slot is the XOR of the handle's HBITS-wide slices, taken from bit 0 upward. The top slice may be shorter than HBITS and is zero-extended (HBITS=6: handle 0x40000000 folds to slot 1).
- R2: With LEGACY=1 the 5-bit channel id, shifted left by HBITS-4 and truncated to HBITS bits, is XORed into the folded value. With LEGACY=0 the channel has no effect on the slot.
- R3: Slot s occupies RAM words 2s (handle) and 2s+1 (context). rsp_slot reports the slot a successful command used.
- R4: Legacy context word: bits 15:0 = instance address bits 19:4, bits 17:16 = engine, bits 28:24 = channel, bit 31 = 1. Newer context word: bits 15:0 = instance address bits 19:4, bits 21:20 = engine, all other bits 0.
- R5: A slot is occupied when context bit 31 is set (legacy), or when the context word is nonzero (newer). An insert that encodes to an all-zero newer word reports success but leaves the slot free.
- R6: An insert starts at the home slot and moves forward one slot at a time, wrapping to slot 0 after the last slot. It stores the binding in the first free slot and responds with rsp_hit=1, status 0 (ok).
- R7: A lookup probes in the same order and matches only a slot that is occupied and whose handle word equals the request; free slots do not end the probe. A hit returns rsp_hit=1, status 0, rsp_inst = stored field shifted left by 4, and rsp_engine.
- R8: A remove finds its entry by the same rule as a lookup and writes zero to both words of that slot. A later lookup of that handle misses, and entries probed past that slot stay reachable.
- R9: If the probe comes back to the home slot without success, the command fails: status 1 (full) for an insert, status 2 (not found) for a lookup or remove.
- R10: Reset clears every table word. req_ready stays low for at least 2^(HBITS+1)-1 cycles after reset is released, until the clearing completes.
- R11: Only one command is in flight at a time: req_ready drops in the cycle after a request is accepted, and rsp_valid is a single-cycle pulse.
- R12: A failed command returns rsp_hit=0 with rsp_inst, rsp_engine and rsp_slot all zero. Op codes: 0 = lookup, 1 = insert, 2 = remove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts table clearing |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Engine idle and able to accept a command |
| req_op | input | 2 | 0 lookup, 1 insert, 2 remove |
| req_handle | input | 32 | Object handle |
| req_chan | input | 5 | Channel id |
| req_inst | input | 20 | Instance byte address (bits 3:0 not stored) |
| req_engine | input | 2 | Engine number for insert |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Command succeeded |
| rsp_status | output | 2 | 0 ok, 1 table full, 2 not found |
| rsp_inst | output | 20 | Instance address from a lookup hit |
| rsp_engine | output | 2 | Engine from a lookup hit |
| rsp_slot | output | HBITS | Slot used by a successful command |

## Verification
Several properties are checked on every cycle. The response is always a single pulse, and req_ready drops after each accepted request. Every failed response carries zeroed fields and a status that matches its op: full only for an insert, not-found only for a lookup or remove. Each probe begins at the home slot, and every context write directly follows the handle write of the same command. Whether the engine finds the correct slot can only be shown by the bench's scenarios, which compare each response against a reference model of the fold, the channel mix and the wrapping probe order. These scenarios cover colliding handles, wraparound past the last slot, a hole left by a removal, a completely full table, and a newer-encoding entry that encodes to zero and so leaves its slot free.

// File: rtl/objhash_pkg.sv
package objhash_pkg;
  localparam int CHAN_W = 5;
  localparam int ENG_W  = 2;
  localparam int INST_W = 20;
  localparam int IDX_W  = 16;

  localparam logic [1:0] OP_LOOKUP = 2'd0;
  localparam logic [1:0] OP_INSERT = 2'd1;
  localparam logic [1:0] OP_REMOVE = 2'd2;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_FULL = 2'd1;
  localparam logic [1:0] ST_MISS = 2'd2;

  typedef enum logic [3:0] {
    S_CLEAR, S_IDLE, S_HASH, S_RD_CTX, S_RD_HDL, S_CHECK, S_WR0, S_WR1, S_DONE
  } eng_state_t;
endpackage

// File: rtl/objhash_fold.sv
module objhash_fold
  import objhash_pkg::*;
#(
  parameter int HBITS  = 6,
  parameter bit LEGACY = 1'b1
) (
  input  logic [31:0]       handle,
  input  logic [CHAN_W-1:0] chan,
  output logic [HBITS-1:0]  slot
);
  localparam int NSLICE = (32 + HBITS - 1) / HBITS;
  localparam int CSHIFT = HBITS - 4;

  logic [HBITS-1:0] folded;

  always_comb begin
    folded = '0;
    for (int s = 0; s < NSLICE; s++) begin
      folded = folded ^ HBITS'(handle >> (s * HBITS));
    end
  end

  generate
    if (LEGACY) begin : g_chan_mix
      assign slot = folded ^ HBITS'(32'(chan) << CSHIFT);
    end else begin : g_no_chan
      logic [CHAN_W-1:0] unused_chan;
      assign unused_chan = chan;
      assign slot = folded;
    end
  endgenerate
endmodule

// File: rtl/objhash_ctx.sv
module objhash_ctx
  import objhash_pkg::*;
#(
  parameter bit LEGACY = 1'b1
) (
  input  logic [INST_W-1:0] enc_inst,
  input  logic [ENG_W-1:0]  enc_eng,
  input  logic [CHAN_W-1:0] enc_chan,
  output logic [31:0]       enc_word,
  input  logic [31:0]       dec_word,
  output logic              dec_occ,
  output logic [INST_W-1:0] dec_inst,
  output logic [ENG_W-1:0]  dec_eng
);
  logic [IDX_W-1:0] idx_field;
  assign idx_field = enc_inst[INST_W-1:INST_W-IDX_W];
  assign dec_inst  = {dec_word[IDX_W-1:0], {(INST_W-IDX_W){1'b0}}};

  logic [INST_W-IDX_W-1:0] unused_inst_low;
  assign unused_inst_low = enc_inst[INST_W-IDX_W-1:0];

  generate
    if (LEGACY) begin : g_legacy
      assign enc_word = {1'b1, 2'b00, enc_chan, 6'b000000, enc_eng, idx_field};
      assign dec_occ  = dec_word[31];
      assign dec_eng  = dec_word[17:16];
      logic [13:0] unused_dec;
      assign unused_dec = dec_word[30:17+1-1-0+1-1];
    end else begin : g_newer
      assign enc_word = {10'b0, enc_eng, 4'b0000, idx_field};
      assign dec_occ  = |dec_word;
      assign dec_eng  = dec_word[21:20];
      logic [CHAN_W-1:0] unused_chan;
      assign unused_chan = enc_chan;
    end
  endgenerate
endmodule

// File: rtl/objhash_ram.sv
module objhash_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/objhash_engine.sv
module objhash_engine
  import objhash_pkg::*;
#(
  parameter int HBITS  = 6,
  parameter bit LEGACY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [31:0]       req_handle,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [INST_W-1:0] req_inst,
  input  logic [ENG_W-1:0]  req_engine,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_status,
  output logic [INST_W-1:0] rsp_inst,
  output logic [ENG_W-1:0]  rsp_engine,
  output logic [HBITS-1:0]  rsp_slot
);
  localparam int AW = HBITS + 1;
  localparam logic [AW-1:0] CLR_LAST = '1;

  eng_state_t state, nstate;

  logic [AW-1:0]     clr_cnt;
  logic              clr_done;
  logic [HBITS-1:0]  probe, home, probe_nxt, home_slot;
  logic [1:0]        op_q;
  logic [31:0]       handle_q;
  logic [CHAN_W-1:0] chan_q;
  logic [INST_W-1:0] inst_q;
  logic [ENG_W-1:0]  eng_q;
  logic [31:0]       ctx_q;

  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [31:0]       ram_wd, ram_q;

  logic [31:0]       enc_word, dec_word;
  logic              dec_occ;
  logic [INST_W-1:0] dec_inst;
  logic [ENG_W-1:0]  dec_eng;

  logic do_adv, fin_ok, fin_fail;

  objhash_fold #(.HBITS(HBITS), .LEGACY(LEGACY)) u_fold (
    .handle (handle_q),
    .chan   (chan_q),
    .slot   (home_slot)
  );

  assign dec_word = (state == S_CHECK) ? ctx_q : ram_q;

  objhash_ctx #(.LEGACY(LEGACY)) u_ctx (
    .enc_inst (inst_q),
    .enc_eng  (eng_q),
    .enc_chan (chan_q),
    .enc_word (enc_word),
    .dec_word (dec_word),
    .dec_occ  (dec_occ),
    .dec_inst (dec_inst),
    .dec_eng  (dec_eng)
  );

  objhash_ram #(.AW(AW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wd),
    .rdata (ram_q)
  );

  // RAM port sequencing: even word = handle, odd word = context
  always_comb begin
    ram_we   = 1'b0;
    ram_addr = {probe, 1'b1};
    ram_wd   = '0;
    case (state)
      S_CLEAR:  begin ram_we = 1'b1; ram_addr = clr_cnt; end
      S_RD_CTX: ram_addr = {probe, 1'b1};
      S_RD_HDL: ram_addr = {probe, 1'b0};
      S_WR0: begin
        ram_we   = 1'b1;
        ram_addr = {probe, 1'b0};
        ram_wd   = (op_q == OP_INSERT) ? handle_q : 32'h0;
      end
      S_WR1: begin
        ram_we   = 1'b1;
        ram_addr = {probe, 1'b1};
        ram_wd   = (op_q == OP_INSERT) ? enc_word : 32'h0;
      end
      default: ;
    endcase
  end

  assign probe_nxt = probe + 1'b1;

  always_comb begin
    nstate   = state;
    do_adv   = 1'b0;
    fin_ok   = 1'b0;
    fin_fail = 1'b0;
    case (state)
      S_CLEAR:  if (clr_cnt == CLR_LAST) nstate = S_IDLE;
      S_IDLE:   if (req_valid) nstate = S_HASH;
      S_HASH:   nstate = S_RD_CTX;
      S_RD_CTX: nstate = S_RD_HDL;
      S_RD_HDL: begin
        if (op_q == OP_INSERT) begin
          if (!dec_occ) nstate = S_WR0;
          else          do_adv = 1'b1;
        end else begin
          if (dec_occ) nstate = S_CHECK;
          else         do_adv = 1'b1;
        end
      end
      S_CHECK: begin
        if (ram_q == handle_q) begin
          if (op_q == OP_REMOVE) nstate = S_WR0;
          else                   fin_ok = 1'b1;
        end else begin
          do_adv = 1'b1;
        end
      end
      S_WR0:  nstate = S_WR1;
      S_WR1:  fin_ok = 1'b1;
      S_DONE: nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
    if (do_adv) begin
      if (probe_nxt == home) fin_fail = 1'b1;
      else                   nstate   = S_RD_CTX;
    end
    if (fin_ok || fin_fail) nstate = S_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_CLEAR;
      clr_cnt    <= '0;
      clr_done   <= 1'b0;
      probe      <= '0;
      home       <= '0;
      op_q       <= '0;
      handle_q   <= '0;
      chan_q     <= '0;
      inst_q     <= '0;
      eng_q      <= '0;
      ctx_q      <= '0;
      rsp_hit    <= 1'b0;
      rsp_status <= ST_OK;
      rsp_inst   <= '0;
      rsp_engine <= '0;
      rsp_slot   <= '0;
    end else begin
      state <= nstate;
      if (state == S_CLEAR) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == CLR_LAST) clr_done <= 1'b1;
      end
      if (state == S_IDLE && req_valid) begin
        op_q     <= req_op;
        handle_q <= req_handle;
        chan_q   <= req_chan;
        inst_q   <= req_inst;
        eng_q    <= req_engine;
      end
      if (state == S_HASH) begin
        home  <= home_slot;
        probe <= home_slot;
      end
      if (state == S_RD_HDL) ctx_q <= ram_q;
      if (do_adv && !fin_fail) probe <= probe_nxt;
      if (fin_ok) begin
        rsp_hit    <= 1'b1;
        rsp_status <= ST_OK;
        rsp_slot   <= probe;
        rsp_inst   <= (op_q == OP_INSERT || op_q == OP_REMOVE) ? '0 : dec_inst;
        rsp_engine <= (op_q == OP_INSERT || op_q == OP_REMOVE) ? '0 : dec_eng;
      end else if (fin_fail) begin
        rsp_hit    <= 1'b0;
        rsp_status <= (op_q == OP_INSERT) ? ST_FULL : ST_MISS;
        rsp_slot   <= '0;
        rsp_inst   <= '0;
        rsp_engine <= '0;
      end
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_DONE);

  // R11: response is a single-cycle pulse
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11: accepted request blocks further requests
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R12: failures carry zeroed fields and a failure status
  p_miss_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_inst == '0 && rsp_engine == '0 &&
                                 rsp_slot == '0 && rsp_status != ST_OK));

  // R7: a success always reports ok status
  p_hit_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> rsp_status == ST_OK);

  // R9: full only for insert, not-found only for lookup/remove
  p_full_insert_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_FULL) |-> op_q == OP_INSERT);
  p_miss_other_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_MISS) |-> op_q != OP_INSERT);

  // R3: the first probe of every command is at the home slot
  p_home_first_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_CTX && $past(state) == S_HASH) |-> probe == home);

  // R8: a context write follows the handle write of the same slot
  p_write_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_WR1) |-> ($past(state) == S_WR0 && $stable(probe)));

  // R10: no command accepted before the table is cleared
  p_clear_gate_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> clr_done);
endmodule

// File: tb/test_objhash_engine.sv
module test_objhash_engine;
  localparam int HB    = 6;
  localparam int NSLOT = 1 << HB;
  localparam int NV    = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_handle = '0;
  logic [4:0]  req_chan = '0;
  logic [19:0] req_inst = '0;
  logic [1:0]  req_engine = '0;

  logic [1:0]  rdy, rv, hit;
  logic [1:0]  st   [2];
  logic [19:0] oin  [2];
  logic [1:0]  oeng [2];
  logic [HB-1:0] oslot [2];

  objhash_engine #(.HBITS(HB), .LEGACY(1'b1)) i_objhash_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_op(req_op), .req_handle(req_handle), .req_chan(req_chan),
    .req_inst(req_inst), .req_engine(req_engine),
    .rsp_valid(rv[0]), .rsp_hit(hit[0]), .rsp_status(st[0]),
    .rsp_inst(oin[0]), .rsp_engine(oeng[0]), .rsp_slot(oslot[0]));

  objhash_engine #(.HBITS(HB), .LEGACY(1'b0)) i_objhash_engine_nw (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_op(req_op), .req_handle(req_handle), .req_chan(req_chan),
    .req_inst(req_inst), .req_engine(req_engine),
    .rsp_valid(rv[1]), .rsp_hit(hit[1]), .rsp_status(st[1]),
    .rsp_inst(oin[1]), .rsp_engine(oeng[1]), .rsp_slot(oslot[1]));

  int checks = 0;
  int fails  = 0;

  logic [31:0] mh [2][NSLOT];
  logic [31:0] mc [2][NSLOT];
  logic        e_hit [2];
  logic [1:0]  e_st [2];
  logic [19:0] e_inst [2];
  logic [1:0]  e_eng [2];
  logic [HB-1:0] e_slot [2];
  logic        g_hit [2];
  logic [1:0]  g_st [2];
  logic [19:0] g_inst [2];
  logic [1:0]  g_eng [2];
  logic [HB-1:0] g_slot [2];

  // op, handle, chan, inst, engine, expected hit
  localparam logic [61:0] VEC [NV] = '{
    {2'd1, 32'h00000000, 5'd0, 20'h00100, 2'd1, 1'b1},
    {2'd1, 32'h00000041, 5'd0, 20'h00200, 2'd2, 1'b1},
    {2'd1, 32'h00001001, 5'd0, 20'h00300, 2'd3, 1'b1},
    {2'd0, 32'h00001001, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd0, 32'h00000041, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd0, 32'h00000082, 5'd0, 20'h00000, 2'd0, 1'b0},
    {2'd1, 32'h0000003F, 5'd0, 20'h00400, 2'd1, 1'b1},
    {2'd1, 32'h00000FC0, 5'd0, 20'h00500, 2'd2, 1'b1},
    {2'd0, 32'h00000FC0, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd2, 32'h00000041, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd0, 32'h00000041, 5'd0, 20'h00000, 2'd0, 1'b0},
    {2'd0, 32'h00001001, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd1, 32'h00000082, 5'd0, 20'h00600, 2'd1, 1'b1},
    {2'd2, 32'hDEADBEEF, 5'd0, 20'h00000, 2'd0, 1'b0},
    {2'd1, 32'h12345678, 5'd3, 20'hABCD0, 2'd2, 1'b1},
    {2'd0, 32'h12345678, 5'd3, 20'h00000, 2'd0, 1'b1},
    {2'd0, 32'h12345678, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd1, 32'h00000005, 5'd0, 20'h0001F, 2'd0, 1'b1},
    {2'd0, 32'h00000005, 5'd0, 20'h00000, 2'd0, 1'b1},
    {2'd2, 32'h0000003F, 5'd0, 20'h00000, 2'd0, 1'b1}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [HB-1:0] mfold(input logic [31:0] h, input logic [4:0] ch,
                                          input bit leg);
    logic [HB-1:0] r = '0;
    for (int b = 0; b < 32; b++) r[b % HB] = r[b % HB] ^ h[b];
    if (leg) for (int b = 0; b < 5; b++)
      if (b + HB - 4 < HB) r[b + HB - 4] = r[b + HB - 4] ^ ch[b];
    return r;
  endfunction

  function automatic logic [31:0] menc(input int m, input logic [4:0] ch,
                                       input logic [19:0] inst, input logic [1:0] eng);
    if (m == 0) return {1'b1, 2'b00, ch, 6'b0, eng, inst[19:4]};
    return {10'b0, eng, 4'b0, inst[19:4]};
  endfunction

  task automatic model_clear();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < NSLOT; s++) begin mh[m][s] = '0; mc[m][s] = '0; end
  endtask

  task automatic model_op(input int m, input logic [1:0] op, input logic [31:0] h,
                          input logic [4:0] ch, input logic [19:0] inst,
                          input logic [1:0] eng);
    int home;
    bit done = 1'b0;
    home = int'(mfold(h, ch, m == 0));
    e_hit[m] = 1'b0; e_st[m] = (op == 2'd1) ? 2'd1 : 2'd2;
    e_inst[m] = '0; e_eng[m] = '0; e_slot[m] = '0;
    for (int k = 0; k < NSLOT; k++) begin
      int s;
      bit occ;
      s = (home + k) % NSLOT;
      occ = (m == 0) ? mc[m][s][31] : (mc[m][s] != 0);
      if (!done) begin
        if (op == 2'd1) begin
          if (!occ) begin
            mh[m][s] = h; mc[m][s] = menc(m, ch, inst, eng);
            done = 1'b1;
          end
        end else if (occ && mh[m][s] == h) begin
          if (op == 2'd0) begin
            e_inst[m] = {mc[m][s][15:0], 4'b0};
            e_eng[m]  = (m == 0) ? mc[m][s][17:16] : mc[m][s][21:20];
          end else begin
            mh[m][s] = '0; mc[m][s] = '0;
          end
          done = 1'b1;
        end
        if (done) begin
          e_hit[m] = 1'b1; e_st[m] = 2'd0; e_slot[m] = HB'(s);
        end
      end
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                        input logic [19:0] inst, input logic [1:0] eng, input string rq);
    bit got0, got1;
    int wait_n;
    while (rdy != 2'b11) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_handle = h; req_chan = ch;
    req_inst = inst; req_engine = eng;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "ready after accept", 32'(rdy), 32'h0);
    for (int m = 0; m < 2; m++) model_op(m, op, h, ch, inst, eng);
    got0 = 1'b0; got1 = 1'b0; wait_n = 0;
    while (!(got0 && got1) && wait_n < 1000) begin
      if (rv[0] && !got0) begin
        got0 = 1'b1; g_hit[0] = hit[0]; g_st[0] = st[0]; g_inst[0] = oin[0];
        g_eng[0] = oeng[0]; g_slot[0] = oslot[0];
      end
      if (rv[1] && !got1) begin
        got1 = 1'b1; g_hit[1] = hit[1]; g_st[1] = st[1]; g_inst[1] = oin[1];
        g_eng[1] = oeng[1]; g_slot[1] = oslot[1];
      end
      @(negedge clk);
      wait_n++;
    end
    chk("R11", "response seen", {30'b0, got1, got0}, 32'h3);
    for (int m = 0; m < 2; m++) begin
      chk(rq, m == 0 ? "legacy hit" : "newer hit", 32'(g_hit[m]), 32'(e_hit[m]));
      chk(rq, m == 0 ? "legacy status" : "newer status", 32'(g_st[m]), 32'(e_st[m]));
      chk(rq, m == 0 ? "legacy inst" : "newer inst", 32'(g_inst[m]), 32'(e_inst[m]));
      chk(rq, m == 0 ? "legacy engine" : "newer engine", 32'(g_eng[m]), 32'(e_eng[m]));
      chk(rq, m == 0 ? "legacy slot" : "newer slot", 32'(g_slot[m]), 32'(e_slot[m]));
    end
  endtask

  task automatic do_reset();
    int low_n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R10", "ready during clear", 32'(rdy), 32'h0);
    chk("R12", "no response during clear", 32'(rv), 32'h0);
    low_n = 1;
    while (rdy != 2'b11 && low_n < 1000) begin @(negedge clk); low_n++; end
    chk("R10", "clear cycles >= table words-1", 32'(low_n >= (2 * NSLOT - 1)), 32'h1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();

    // table walk: collisions (R6), wrap (R6), hole after remove (R8), handle-only match (R7)
    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      string rq;
      v = VEC[i];
      rq = (v[61:60] == 2'd1) ? "R6" : (v[61:60] == 2'd2) ? "R8" : "R7";
      run_op(v[61:60], v[59:28], v[27:23], v[22:3], v[2:1], rq);
      chk(rq, "table expected hit legacy", 32'(g_hit[0]), 32'(v[0]));
      chk(rq, "table expected hit newer", 32'(g_hit[1]), 32'(v[0]));
    end

    // R10: reset empties the table
    do_reset();
    run_op(2'd0, 32'h00001001, 5'd0, 20'h0, 2'd0, "R10");
    chk("R10", "lookup after reset", 32'(g_hit[0]), 32'h0);

    // R1: partial top slice folds into bit 0
    run_op(2'd1, 32'h40000000, 5'd0, 20'h00800, 2'd1, "R1");
    chk("R1", "partial slice slot", 32'(g_slot[0]), 32'h1);

    // R2: channel moves legacy slot only
    run_op(2'd1, 32'h00000000, 5'd1, 20'h00900, 2'd2, "R2");
    chk("R2", "legacy channel slot", 32'(g_slot[0]), 32'h4);
    chk("R2", "newer channel slot", 32'(g_slot[1]), 32'h0);

    // R4/R3: stored instance loses low nibble, engine round trip
    run_op(2'd0, 32'h00000000, 5'd1, 20'h0, 2'd0, "R4");
    chk("R4", "legacy inst", 32'(g_inst[0]), 32'h00900);
    chk("R4", "newer engine", 32'(g_eng[1]), 32'h2);

    // R5: all-zero newer word leaves the slot free
    run_op(2'd1, 32'h00000077, 5'd0, 20'h00005, 2'd0, "R5");
    chk("R5", "zero word insert reports ok", 32'(g_hit[1]), 32'h1);
    run_op(2'd0, 32'h00000077, 5'd0, 20'h0, 2'd0, "R5");
    chk("R5", "legacy sees entry", 32'(g_hit[0]), 32'h1);
    chk("R5", "newer slot stays free", 32'(g_hit[1]), 32'h0);

    // R9: fill the table completely
    do_reset();
    for (int i = 0; i < NSLOT; i++)
      run_op(2'd1, 32'h00010000 + 32'(i * 37), 5'(i % 32), 20'((i + 1) << 8), 2'(i % 4), "R6");
    run_op(2'd1, 32'hCAFE0000, 5'd2, 20'h01000, 2'd1, "R9");
    chk("R9", "insert into full table", 32'(g_st[0]), 32'h1);
    chk("R12", "full slot zero", 32'(g_slot[0]), 32'h0);
    run_op(2'd0, 32'hCAFE0000, 5'd2, 20'h0, 2'd0, "R9");
    chk("R9", "lookup absent in full table", 32'(g_st[0]), 32'h2);
    run_op(2'd2, 32'h00010000 + 32'(5 * 37), 5'd5, 20'h0, 2'd0, "R8");
    run_op(2'd1, 32'hCAFE0000, 5'd2, 20'h01000, 2'd1, "R6");
    chk("R6", "insert after removal", 32'(g_hit[0]), 32'h1);
    run_op(2'd0, 32'hCAFE0000, 5'd2, 20'h0, 2'd0, "R7");
    chk("R7", "lookup refilled slot inst", 32'(g_inst[0]), 32'h01000);

    finish_run();
  end
endmodule